// File: doc/BRIEF.md
# Multi-channel ADC threshold monitor

This block watches up to eight monitor channels. Each channel names one input of an external ADC and carries a low and a high 16-bit threshold. A channel is marked for measurement either when software writes a start-round command or when the shared interval timer it has chosen fires. A scheduler serves the marked channels one at a time in round-robin order. For each one it waits a per-channel settle delay, counted in timer ticks, and then runs a request/acknowledge exchange with the ADC. It compares the returned code with both thresholds and records any crossing in sticky status bitmaps.

Software reaches the configuration, timer intervals and status through a byte-wide register port. Writes take effect on the clock edge and reads are combinational. A single level interrupt is raised while any measurement-enabled channel holds a status bit whose own interrupt enable is set.

Top module: `adc_limit_monitor`

## Requirements
- R1: After reset both status bitmaps (0x0A low, 0x0B high) read 0, `irq` and `adc_req` are low, and register 0x0F reads the channel count, 8.
- R2: Channel n owns bytes 0x60+8n to 0x67+8n. The bytes are laid out as follows:
  - byte 0: ADC input number. A write of a value of 0xC0 or above is ignored.
  - bytes 1 and 2: low threshold, least significant byte first.
  - bytes 3 and 4: high threshold, in the same byte order.
  - byte 5, bits 1:0: timer select.
  - byte 6: settle code in bits 3:0 and calibration code in bits 5:4.
  - byte 7: measurement enable in bit 7, high interrupt enable in bit 1, low interrupt enable in bit 0.
  - Unimplemented bits read as 0.
- R3: Bit 7 of 0x46 is the global enable and reads back. Writing 1 to bit 7 of 0x47 marks every measurement-enabled channel for one measurement. While the global enable is 0, nothing is marked and no new request starts.
- R4: Marked channels are served one at a time, in round-robin order starting after the channel served last (channel 0 first after reset). `adc_req` stays high with `adc_sel` stable until `adc_ack` is seen.
- R5: A returned code at or below the low threshold sets the channel's bit in 0x0A. A code at or above the high threshold sets its bit in 0x0B.
- R6: Status bits are sticky. Writing 1 to a bit clears it, and writing 0 has no effect. If a set and a clear of the same bit happen in one cycle, the set wins.
- R7: `irq` is high one cycle after some channel has measurement enable set together with either (low status and low enable) or (high status and high enable). Otherwise it is low.
- R8: After a channel is picked, `adc_req` rises only once as many `tick` pulses as the settle code have been seen. A code of 0 adds no wait.
- R9: Timer intervals are set in three places: 0x44 holds timer 1, 0x45 bits 7:4 hold timer 2, and 0x45 bits 3:0 hold timer 3. A timer with a nonzero interval V fires on every V-th tick while the global enable is set, and an interval of 0 stops it. Timer select values 0, 1 and 2 bind a channel to timers 1, 2 and 3, and 3 binds it to none.
- R10: A channel with measurement enable clear is never requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tick | input | 1 | Timebase pulse for the interval timers and settle delays |
| adc_req | output | 1 | Conversion request to the ADC |
| adc_sel | output | 8 | ADC input number for the current request |
| adc_ack | input | 1 | ADC result valid; ends the request |
| adc_code | input | 16 | ADC result code, taken while `adc_ack` is high |
| irq | output | 1 | Level interrupt |

## Verification
Codes are returned below, exactly on, just inside and above each threshold. This separates inclusive from exclusive comparison, and low crossings from high ones. A second start command is issued while a request is still outstanding, so that the pending set differs between a round-robin pick and a lowest-index pick. The tests also count ticks against a settle code and against a timer interval, which exposes off-by-one errors in either counter. Interrupt enables, measurement enables and the global enable are each toggled on their own while status is held, so that each gate is seen to act alone.

// File: rtl/alm_pkg.sv
`timescale 1ns/1ps
package alm_pkg;
   localparam int unsigned CODE_W   = 16;
   localparam int unsigned NUM_TMR  = 3;

   localparam logic [7:0] A_LO_STAT  = 8'h0A;
   localparam logic [7:0] A_HI_STAT  = 8'h0B;
   localparam logic [7:0] A_CH_COUNT = 8'h0F;
   localparam logic [7:0] A_TMR1     = 8'h44;
   localparam logic [7:0] A_TMR23    = 8'h45;
   localparam logic [7:0] A_GLOBAL   = 8'h46;
   localparam logic [7:0] A_KICK     = 8'h47;
   localparam logic [7:0] A_WIN_BASE = 8'h60;

   typedef enum logic [1:0] {
      TSEL_T1  = 2'd0,
      TSEL_T2  = 2'd1,
      TSEL_T3  = 2'd2,
      TSEL_OFF = 2'd3
   } tsel_e;

   typedef enum logic [1:0] {
      S_IDLE   = 2'd0,
      S_SETTLE = 2'd1,
      S_REQ    = 2'd2
   } sched_e;

   typedef struct packed {
      logic [7:0]        src;
      logic [CODE_W-1:0] lo_thr;
      logic [CODE_W-1:0] hi_thr;
      tsel_e             tsel;
      logic [1:0]        cal;
      logic [3:0]        settle;
      logic              meas_en;
      logic              hi_ie;
      logic              lo_ie;
   } chan_cfg_t;
endpackage

// File: rtl/alm_interval_timer.sv
`timescale 1ns/1ps
module alm_interval_timer #(
   parameter int unsigned IV_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run_i,
   input  logic            tick_i,
   input  logic [IV_W-1:0] interval_i,
   output logic            fire_o
);
   logic [IV_W-1:0] cnt_q;
   logic [IV_W:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt_q} + 1'b1;
   assign fire_o  = run_i && tick_i && (interval_i != '0) &&
                    (cnt_inc >= {1'b0, interval_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run_i || interval_i == '0 || fire_o)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= cnt_inc[IV_W-1:0];
   end
endmodule

// File: rtl/alm_regs.sv
`timescale 1ns/1ps
module alm_regs import alm_pkg::*; #(
   parameter int unsigned NUM_CH    = 8,
   parameter int unsigned SEL_LIMIT = 192,
   parameter int unsigned IV1_W     = 8,
   parameter int unsigned IV23_W    = 4,
   localparam int unsigned CH_W     = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [7:0]        addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic [NUM_CH-1:0] lo_st_i,
   input  logic [NUM_CH-1:0] hi_st_i,
   output chan_cfg_t         cfg_o [NUM_CH],
   output logic              global_en_o,
   output logic              kick_o,
   output logic [NUM_CH-1:0] lo_clr_o,
   output logic [NUM_CH-1:0] hi_clr_o,
   output logic [IV1_W-1:0]  iv1_o,
   output logic [IV23_W-1:0] iv2_o,
   output logic [IV23_W-1:0] iv3_o
);
   localparam logic [8:0] SEL_LIM9 = 9'(SEL_LIMIT);
   localparam logic [8:0] WIN_END  = 9'(A_WIN_BASE) + 9'(8 * NUM_CH);

   logic            win_hit;
   logic [7:0]      win_off;
   logic [CH_W-1:0] ch_idx;
   logic [2:0]      byte_idx;

   assign win_hit  = ({1'b0, addr} >= {1'b0, A_WIN_BASE}) && ({1'b0, addr} < WIN_END);
   assign win_off  = addr - A_WIN_BASE;
   assign ch_idx   = win_off[CH_W+2:3];
   assign byte_idx = win_off[2:0];

   assign kick_o   = we && (addr == A_KICK) && wdata[7];
   assign lo_clr_o = (we && addr == A_LO_STAT) ? wdata[NUM_CH-1:0] : '0;
   assign hi_clr_o = (we && addr == A_HI_STAT) ? wdata[NUM_CH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         global_en_o <= 1'b0;
         iv1_o       <= '0;
         iv2_o       <= '0;
         iv3_o       <= '0;
      end else if (we) begin
         if (addr == A_GLOBAL) global_en_o <= wdata[7];
         if (addr == A_TMR1)   iv1_o <= wdata[IV1_W-1:0];
         if (addr == A_TMR23) begin
            iv2_o <= wdata[2*IV23_W-1:IV23_W];
            iv3_o <= wdata[IV23_W-1:0];
         end
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_win
      chan_cfg_t q;
      logic      hit;
      assign hit      = we && win_hit && (ch_idx == CH_W'(c));
      assign cfg_o[c] = q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q      <= '0;
            q.tsel <= TSEL_OFF;
         end else if (hit) begin
            case (byte_idx)
               3'd0: if ({1'b0, wdata} < SEL_LIM9) q.src <= wdata;
               3'd1: q.lo_thr[7:0]  <= wdata;
               3'd2: q.lo_thr[15:8] <= wdata;
               3'd3: q.hi_thr[7:0]  <= wdata;
               3'd4: q.hi_thr[15:8] <= wdata;
               3'd5: q.tsel <= tsel_e'(wdata[1:0]);
               3'd6: begin
                  q.settle <= wdata[3:0];
                  q.cal    <= wdata[5:4];
               end
               default: begin
                  q.meas_en <= wdata[7];
                  q.hi_ie   <= wdata[1];
                  q.lo_ie   <= wdata[0];
               end
            endcase
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (win_hit) begin
         case (byte_idx)
            3'd0: rdata = cfg_o[ch_idx].src;
            3'd1: rdata = cfg_o[ch_idx].lo_thr[7:0];
            3'd2: rdata = cfg_o[ch_idx].lo_thr[15:8];
            3'd3: rdata = cfg_o[ch_idx].hi_thr[7:0];
            3'd4: rdata = cfg_o[ch_idx].hi_thr[15:8];
            3'd5: rdata = {6'd0, cfg_o[ch_idx].tsel};
            3'd6: rdata = {2'd0, cfg_o[ch_idx].cal, cfg_o[ch_idx].settle};
            default: rdata = {cfg_o[ch_idx].meas_en, 5'd0,
                              cfg_o[ch_idx].hi_ie, cfg_o[ch_idx].lo_ie};
         endcase
      end else begin
         case (addr)
            A_LO_STAT:  rdata = 8'(lo_st_i);
            A_HI_STAT:  rdata = 8'(hi_st_i);
            A_CH_COUNT: rdata = 8'(NUM_CH);
            A_TMR1:     rdata = 8'(iv1_o);
            A_TMR23:    rdata = {iv2_o, iv3_o};
            A_GLOBAL:   rdata = {global_en_o, 7'd0};
            default:    rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/alm_sched.sv
`timescale 1ns/1ps
module alm_sched import alm_pkg::*; #(
   parameter int unsigned NUM_CH = 8,
   localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  chan_cfg_t         cfg_i [NUM_CH],
   input  logic              global_en_i,
   input  logic              kick_i,
   input  logic [NUM_TMR-1:0] fire_i,
   input  logic              tick_i,
   input  logic              adc_ack_i,
   input  logic [CODE_W-1:0] adc_code_i,
   output logic              adc_req_o,
   output logic [7:0]        adc_sel_o,
   output logic              res_vld_o,
   output logic [CH_W-1:0]   res_ch_o,
   output logic              res_lo_o,
   output logic              res_hi_o
);
   sched_e            state_q;
   logic [CH_W-1:0]   cur_q, last_q, pick;
   logic [3:0]        scnt_q;
   logic [7:0]        sel_q;
   logic [NUM_CH-1:0] pend_q, pend_set, meas_mask, pend_d;
   logic [3:0]        fire_ext;
   logic              found, take;

   assign fire_ext = 4'(fire_i);

   always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
         logic trig;
         trig = kick_i;
         if (cfg_i[c].tsel != TSEL_OFF)
            trig = trig | fire_ext[cfg_i[c].tsel];
         meas_mask[c] = cfg_i[c].meas_en;
         pend_set[c]  = global_en_i && cfg_i[c].meas_en && trig;
      end
   end

   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int i = 1; i <= NUM_CH; i++) begin
         if (!found && pend_q[(int'(last_q) + i) % NUM_CH]) begin
            found = 1'b1;
            pick  = CH_W'((int'(last_q) + i) % NUM_CH);
         end
      end
   end

   assign take = (state_q == S_IDLE) && found && global_en_i;

   always_comb begin
      pend_d = (pend_q | pend_set) & meas_mask & {NUM_CH{global_en_i}};
      if (take) pend_d[pick] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         cur_q   <= '0;
         last_q  <= CH_W'(NUM_CH - 1);
         scnt_q  <= '0;
         sel_q   <= '0;
         pend_q  <= '0;
      end else begin
         pend_q <= pend_d;
         case (state_q)
            S_IDLE: if (take) begin
               cur_q   <= pick;
               last_q  <= pick;
               sel_q   <= cfg_i[pick].src;
               scnt_q  <= '0;
               state_q <= S_SETTLE;
            end
            S_SETTLE: begin
               if (!global_en_i)
                  state_q <= S_IDLE;
               else if (scnt_q >= cfg_i[cur_q].settle)
                  state_q <= S_REQ;
               else if (tick_i)
                  scnt_q <= scnt_q + 4'd1;
            end
            S_REQ: if (adc_ack_i) state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign adc_req_o = (state_q == S_REQ);
   assign adc_sel_o = sel_q;
   assign res_vld_o = (state_q == S_REQ) && adc_ack_i;
   assign res_ch_o  = cur_q;
   assign res_lo_o  = adc_code_i <= cfg_i[cur_q].lo_thr;
   assign res_hi_o  = adc_code_i >= cfg_i[cur_q].hi_thr;
endmodule

// File: rtl/alm_status.sv
`timescale 1ns/1ps
module alm_status import alm_pkg::*; #(
   parameter int unsigned NUM_CH = 8,
   localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  chan_cfg_t         cfg_i [NUM_CH],
   input  logic              res_vld_i,
   input  logic [CH_W-1:0]   res_ch_i,
   input  logic              res_lo_i,
   input  logic              res_hi_i,
   input  logic [NUM_CH-1:0] lo_clr_i,
   input  logic [NUM_CH-1:0] hi_clr_i,
   output logic [NUM_CH-1:0] lo_st_o,
   output logic [NUM_CH-1:0] hi_st_o,
   output logic              irq_o
);
   logic [NUM_CH-1:0] onehot, lo_set, hi_set;
   logic              irq_d;

   assign onehot = NUM_CH'(1) << res_ch_i;
   assign lo_set = (res_vld_i && res_lo_i) ? onehot : '0;
   assign hi_set = (res_vld_i && res_hi_i) ? onehot : '0;

   always_comb begin
      irq_d = 1'b0;
      for (int c = 0; c < NUM_CH; c++)
         irq_d = irq_d | (cfg_i[c].meas_en &&
                 ((lo_st_o[c] && cfg_i[c].lo_ie) || (hi_st_o[c] && cfg_i[c].hi_ie)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_st_o <= '0;
         hi_st_o <= '0;
         irq_o   <= 1'b0;
      end else begin
         lo_st_o <= (lo_st_o & ~lo_clr_i) | lo_set;
         hi_st_o <= (hi_st_o & ~hi_clr_i) | hi_set;
         irq_o   <= irq_d;
      end
   end
endmodule

// File: rtl/adc_limit_monitor.sv
`timescale 1ns/1ps
module adc_limit_monitor import alm_pkg::*; #(
   parameter int unsigned NUM_CH    = 8,
   parameter int unsigned SEL_LIMIT = 192,
   parameter int unsigned IV1_W     = 8,
   parameter int unsigned IV23_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [7:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              tick,
   output logic              adc_req,
   output logic [7:0]        adc_sel,
   input  logic              adc_ack,
   input  logic [CODE_W-1:0] adc_code,
   output logic              irq
);
   localparam int unsigned CH_W = $clog2(NUM_CH);

   if (NUM_CH < 2 || NUM_CH > 8) begin : g_bad_ch
      $error("NUM_CH must lie in 2..8");
   end
   if (IV1_W > 8 || 2 * IV23_W != 8) begin : g_bad_iv
      $error("timer interval widths do not fit their registers");
   end
   if (SEL_LIMIT > 256) begin : g_bad_sel
      $error("SEL_LIMIT exceeds byte range");
   end

   chan_cfg_t          cfg [NUM_CH];
   logic               global_en, kick;
   logic [NUM_CH-1:0]  lo_clr, hi_clr, lo_status, hi_status;
   logic [IV1_W-1:0]   iv1;
   logic [IV23_W-1:0]  iv2, iv3;
   logic [IV1_W-1:0]   iv [NUM_TMR];
   logic [NUM_TMR-1:0] fire;
   logic               res_vld, res_lo, res_hi;
   logic [CH_W-1:0]    res_ch;

   alm_regs #(.NUM_CH(NUM_CH), .SEL_LIMIT(SEL_LIMIT), .IV1_W(IV1_W), .IV23_W(IV23_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .lo_st_i(lo_status), .hi_st_i(hi_status), .cfg_o(cfg),
      .global_en_o(global_en), .kick_o(kick), .lo_clr_o(lo_clr), .hi_clr_o(hi_clr),
      .iv1_o(iv1), .iv2_o(iv2), .iv3_o(iv3));

   assign iv[0] = iv1;
   assign iv[1] = IV1_W'(iv2);
   assign iv[2] = IV1_W'(iv3);

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      alm_interval_timer #(.IV_W(IV1_W)) i_tmr (
         .clk(clk), .rst_n(rst_n), .run_i(global_en), .tick_i(tick),
         .interval_i(iv[t]), .fire_o(fire[t]));
   end

   alm_sched #(.NUM_CH(NUM_CH)) i_sched (
      .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .global_en_i(global_en), .kick_i(kick),
      .fire_i(fire), .tick_i(tick), .adc_ack_i(adc_ack), .adc_code_i(adc_code),
      .adc_req_o(adc_req), .adc_sel_o(adc_sel), .res_vld_o(res_vld), .res_ch_o(res_ch),
      .res_lo_o(res_lo), .res_hi_o(res_hi));

   alm_status #(.NUM_CH(NUM_CH)) i_status (
      .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .res_vld_i(res_vld), .res_ch_i(res_ch),
      .res_lo_i(res_lo), .res_hi_i(res_hi), .lo_clr_i(lo_clr), .hi_clr_i(hi_clr),
      .lo_st_o(lo_status), .hi_st_o(hi_status), .irq_o(irq));
endmodule

// File: rtl/alm_checker.sv
`timescale 1ns/1ps
module alm_checker #(
   parameter int unsigned NUM_CH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [7:0]        reg_addr,
   input logic              adc_req,
   input logic [7:0]        adc_sel,
   input logic              adc_ack,
   input logic              irq,
   input logic              global_en,
   input logic [NUM_CH-1:0] lo_st,
   input logic [NUM_CH-1:0] hi_st
);
   // R4: request held with a stable input number until acknowledged
   a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_req && !adc_ack) |=> (adc_req && $stable(adc_sel)));

   // R2: only legal ADC input numbers ever leave the block
   a_r2_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
      adc_req |-> (adc_sel < 8'hC0));

   // R3: a new request starts only while the monitor was enabled
   a_r3_req_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_req) |-> $past(global_en));

   // R6: status bits drop only after a write to their register
   a_r6_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reg_we && reg_addr == 8'h0A) |-> ((lo_st & $past(lo_st)) == $past(lo_st)));

   a_r6_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reg_we && reg_addr == 8'h0B) |-> ((hi_st & $past(hi_st)) == $past(hi_st)));

   // R7: an interrupt always has a recorded crossing behind it
   a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(lo_st | hi_st) != '0));
endmodule

bind adc_limit_monitor alm_checker #(.NUM_CH(NUM_CH)) i_alm_checker (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .adc_req(adc_req), .adc_sel(adc_sel), .adc_ack(adc_ack), .irq(irq),
   .global_en(global_en), .lo_st(lo_status), .hi_st(hi_status));

// File: tb/test_adc_limit_monitor.sv
`timescale 1ns/1ps
module test_adc_limit_monitor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        tick = 1'b0;
   logic        adc_req;
   logic [7:0]  adc_sel;
   logic        adc_ack = 1'b0;
   logic [15:0] adc_code = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   adc_limit_monitor i_adc_limit_monitor (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
      .adc_req(adc_req), .adc_sel(adc_sel), .adc_ack(adc_ack),
      .adc_code(adc_code), .irq(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      chk(req, 32'(d), 32'(exp));
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic cfg_ch(input int ch, input logic [7:0] src, input logic [15:0] lo,
                         input logic [15:0] hi, input logic [7:0] tsel,
                         input logic [7:0] b6, input logic [7:0] b7);
      logic [7:0] base;
      base = 8'h60 + 8'(8 * ch);
      wr(base + 8'd0, src);
      wr(base + 8'd1, lo[7:0]);
      wr(base + 8'd2, lo[15:8]);
      wr(base + 8'd3, hi[7:0]);
      wr(base + 8'd4, hi[15:8]);
      wr(base + 8'd5, tsel);
      wr(base + 8'd6, b6);
      wr(base + 8'd7, b7);
   endtask

   task automatic wait_req(input string req, input logic [7:0] exp_sel);
      bit seen = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (adc_req) begin seen = 1'b1; break; end
      end
      chk({req, " request seen"}, 32'(seen), 32'd1);
      chk({req, " adc_sel"}, 32'(adc_sel), 32'(exp_sel));
   endtask

   task automatic give_ack(input logic [15:0] code);
      adc_ack = 1'b1; adc_code = code;
      @(negedge clk);
      adc_ack = 1'b0;
   endtask

   task automatic serve(input string req, input logic [7:0] exp_sel, input logic [15:0] code);
      wait_req(req, exp_sel);
      give_ack(code);
   endtask

   task automatic no_req(input string req, input int n);
      bit seen = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (adc_req) seen = 1'b1;
      end
      chk({req, " no request"}, 32'(seen), 32'd0);
   endtask

   task automatic irq_chk(input string req, input logic exp);
      repeat (2) @(negedge clk);
      chk(req, 32'(irq), 32'(exp));
   endtask

   task automatic t_reset();
      chk("R1 irq after reset", 32'(irq), 32'd0);
      chk("R1 adc_req after reset", 32'(adc_req), 32'd0);
      rd_chk("R1 low status", 8'h0A, 8'h00);
      rd_chk("R1 high status", 8'h0B, 8'h00);
      rd_chk("R1 channel count", 8'h0F, 8'h08);
   endtask

   task automatic t_window();
      cfg_ch(3, 8'h21, 16'h1234, 16'hABCD, 8'h02, 8'h25, 8'h83);
      rd_chk("R2 src", 8'h78, 8'h21);
      rd_chk("R2 lo lsb", 8'h79, 8'h34);
      rd_chk("R2 lo msb", 8'h7A, 8'h12);
      rd_chk("R2 hi lsb", 8'h7B, 8'hCD);
      rd_chk("R2 hi msb", 8'h7C, 8'hAB);
      rd_chk("R2 tsel", 8'h7D, 8'h02);
      rd_chk("R2 settle/cal", 8'h7E, 8'h25);
      rd_chk("R2 enables", 8'h7F, 8'h83);
      wr(8'h78, 8'hC5);
      rd_chk("R2 illegal src ignored", 8'h78, 8'h21);
      wr(8'h7F, 8'hFF);
      rd_chk("R2 unused enable bits", 8'h7F, 8'h83);
      wr(8'h7F, 8'h00);
   endtask

   task automatic t_round();
      wr(8'h46, 8'h80);
      rd_chk("R3 global readback", 8'h46, 8'h80);
      cfg_ch(2, 8'h10, 16'h0100, 16'h0F00, 8'h03, 8'h00, 8'h83);
      cfg_ch(5, 8'h35, 16'h0200, 16'h0800, 8'h03, 8'h00, 8'h83);
      cfg_ch(6, 8'h40, 16'h0000, 16'hFFFF, 8'h03, 8'h00, 8'h03);
      irq_chk("R7 no irq before results", 1'b0);
      wr(8'h47, 8'h80);
      serve("R4 round first", 8'h10, 16'h0050);
      serve("R4 round second", 8'h35, 16'h0900);
      no_req("R10 disabled channel 6", 30);
      rd_chk("R5 low crossing", 8'h0A, 8'h04);
      rd_chk("R5 high crossing", 8'h0B, 8'h20);
      irq_chk("R7 irq on crossing", 1'b1);
   endtask

   task automatic t_irq_gate();
      wr(8'h77, 8'h82);
      irq_chk("R7 other channel keeps irq", 1'b1);
      wr(8'h8F, 8'h81);
      irq_chk("R7 high enable gates irq", 1'b0);
      rd_chk("R6 status held while gated", 8'h0B, 8'h20);
      wr(8'h8F, 8'h83);
      irq_chk("R7 irq back on", 1'b1);
      wr(8'h0B, 8'h20);
      rd_chk("R6 high cleared by one", 8'h0B, 8'h00);
      irq_chk("R7 low enable gates irq", 1'b0);
      wr(8'h0A, 8'h00);
      rd_chk("R6 zero write keeps status", 8'h0A, 8'h04);
      wr(8'h77, 8'h83);
      irq_chk("R7 low enable restores irq", 1'b1);
      wr(8'h77, 8'h03);
      irq_chk("R7 measurement enable gates irq", 1'b0);
      wr(8'h77, 8'h83);
      wr(8'h0A, 8'h04);
      rd_chk("R6 low cleared", 8'h0A, 8'h00);
      irq_chk("R7 irq drops after clear", 1'b0);
   endtask

   task automatic t_rr();
      cfg_ch(0, 8'h05, 16'h0300, 16'h0400, 8'h03, 8'h00, 8'h83);
      wr(8'h47, 8'h80);
      wait_req("R4 rr pick 0", 8'h05);
      wr(8'h47, 8'h80);
      give_ack(16'h0300);
      serve("R4 rr pick 2", 8'h10, 16'h0101);
      serve("R4 rr pick 5 before 0", 8'h35, 16'h0800);
      serve("R4 rr wrap to 0", 8'h05, 16'h03FF);
      no_req("R4 round finished", 30);
      rd_chk("R5 low boundary inclusive", 8'h0A, 8'h01);
      rd_chk("R5 high boundary inclusive", 8'h0B, 8'h20);
      wr(8'h0A, 8'hFF);
      wr(8'h0B, 8'hFF);
      rd_chk("R6 clear all low", 8'h0A, 8'h00);
      wr(8'h67, 8'h00);
      wr(8'h77, 8'h00);
      wr(8'h8F, 8'h00);
   endtask

   task automatic t_settle();
      cfg_ch(1, 8'h07, 16'h0000, 16'hFFFF, 8'h03, 8'h03, 8'h80);
      wr(8'h47, 8'h80);
      no_req("R8 before first tick", 5);
      pulse_tick();
      no_req("R8 after one tick", 3);
      pulse_tick();
      no_req("R8 after two ticks", 3);
      pulse_tick();
      repeat (3) @(negedge clk);
      chk("R8 request after three ticks", 32'(adc_req), 32'd1);
      serve("R8 settle serve", 8'h07, 16'h1234);
      rd_chk("R5 inside window no low", 8'h0A, 8'h00);
      wr(8'h6E, 8'h00);
   endtask

   task automatic t_timer();
      wr(8'h6D, 8'h01);
      wr(8'h45, 8'h30);
      rd_chk("R9 interval readback", 8'h45, 8'h30);
      pulse_tick();
      no_req("R9 tick 1", 4);
      pulse_tick();
      no_req("R9 tick 2", 4);
      pulse_tick();
      serve("R9 timer 2 fires", 8'h07, 16'h2000);
      pulse_tick();
      pulse_tick();
      no_req("R9 second period early", 4);
      pulse_tick();
      serve("R9 timer 2 fires again", 8'h07, 16'h2000);
      wr(8'h6D, 8'h03);
      repeat (4) pulse_tick();
      no_req("R9 select none", 6);
      wr(8'h45, 8'h00);
      wr(8'h44, 8'h02);
      wr(8'h6D, 8'h00);
      pulse_tick();
      no_req("R9 timer 1 tick 1", 4);
      pulse_tick();
      serve("R9 timer 1 fires", 8'h07, 16'h2000);
      wr(8'h44, 8'h00);
      wr(8'h6D, 8'h03);
   endtask

   task automatic t_global();
      wr(8'h46, 8'h00);
      rd_chk("R3 global off readback", 8'h46, 8'h00);
      wr(8'h47, 8'h80);
      no_req("R3 start ignored while off", 20);
      wr(8'h46, 8'h80);
      no_req("R3 nothing marked while off", 20);
      wr(8'h47, 8'h80);
      serve("R3 start after enable", 8'h07, 16'h2000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_window();
      t_round();
      t_irq_gate();
      t_rr();
      t_settle();
      t_timer();
      t_global();
      repeat (5) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule